// File: doc/BRIEF.md
# ADC Completion DMA Request Generator

This block turns per-source conversion-completion events into DMA request lines, one line for each of eight hardware trigger sources. When a source finishes its conversion sequence and DMA is enabled for it, a pending flag is set for that source. The source's request line to the DMA controller follows that flag for as long as the source stays enabled.

Two clearing policies are available through a single mode bit. In latched mode, a pending request is released only after the block has seen two things: an acknowledge from the DMA and the source's own request level going low. These may arrive in either order, in the same cycle or in different cycles. In pulsed mode, the acknowledge alone clears the request. Software sees the enables, the mode and the pending flags in one control word. Writing 1 to a pending flag clears it; writing 0 leaves it alone.

Top module: `adc_dma_req_gen`

## Requirements
- R1: The control word has the pending flag of source n (0..7) at bit 16+n, the DMA enable of source n at bit n, and the mode bit at bit 31. All other bits read 0, and the whole word reads 0 after reset with no request line high.
- R2: A completion event on an enabled source sets its pending flag, and its request line rises on the cycle after the event.
- R3: A completion event on a source whose enable bit is 0 is ignored: the pending flag and the request line stay low.
- R4: A write with 1 in a pending-flag position clears that flag. A write with 0 in that position leaves the flag as it was, even when the same write changes the enables or the mode.
- R5: Every write loads the eight enable bits and the mode bit from the written word, and they read back unchanged.
- R6: With the mode bit at 0 (latched), a pending request stays high until both an acknowledge and a low level on the source's own request input have been observed since it was set. Either may come first, and the flag clears in the cycle the second one is seen.
- R7: With the mode bit at 1 (pulsed), an acknowledge clears a pending request on the next cycle, whatever the level of the source's request input.
- R8: A completion event in the same cycle as an acknowledge or a software clear wins: the flag is still set on the next cycle, and any earlier acknowledge or release is forgotten.
- R9: Clearing a source's enable drops its request line on the next cycle while its pending flag stays set. Enabling the source again raises the line again.
- R10: An acknowledge on a source with no pending request has no effect, and it does not count toward clearing a later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 8 | Per-source conversion-sequence completion pulse |
| src_req_i | input | 8 | Per-source request level from the trigger source |
| dma_ack_i | input | 8 | Per-source acknowledge from the DMA controller |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| dma_req_o | output | 8 | Per-source DMA request lines |

## Verification
The hardest situation to reach is the latched clear that completes across separate cycles. In that case an acknowledge is remembered while the source request is still high, and the later release has to clear the flag with no further acknowledge. The reverse order is just as hard to reach, as is a new completion event that lands in the clearing cycle. Directed sequences hold the source request high, acknowledge first and release later, and the reverse; one of them pulses completion and acknowledge together. Long random runs then keep the source request levels slow-changing against sparse events and frequent acknowledges, so that these interleavings keep coming up in both modes.

// File: rtl/adc_dma_req_gen.sv
module adc_dma_req_gen #(
  parameter int N_SRC    = 8,
  parameter int WORD_W   = 32,
  parameter int EN_LSB   = 0,
  parameter int STAT_LSB = 16,
  parameter int MODE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  done_i,
  input  logic [N_SRC-1:0]  src_req_i,
  input  logic [N_SRC-1:0]  dma_ack_i,
  input  logic              reg_we,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [N_SRC-1:0]  dma_req_o
);

  logic [N_SRC-1:0] en_q, pend_q, ack_seen_q, rel_seen_q;
  logic             mode_q;
  logic [N_SRC-1:0] pend_d, ack_seen_d, rel_seen_d;
  logic [N_SRC-1:0] set_ev, sw_clr, ack_v, rel_v, hw_clr;

  assign set_ev = done_i & en_q;
  assign sw_clr = reg_we ? reg_wdata[STAT_LSB +: N_SRC] : '0;
  assign ack_v  = ack_seen_q | dma_ack_i;
  assign rel_v  = rel_seen_q | ~src_req_i;
  assign hw_clr = mode_q ? dma_ack_i : (ack_v & rel_v);

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      pend_d[i]     = pend_q[i];
      ack_seen_d[i] = ack_seen_q[i];
      rel_seen_d[i] = rel_seen_q[i];
      if (set_ev[i]) begin
        pend_d[i]     = 1'b1;
        ack_seen_d[i] = 1'b0;
        rel_seen_d[i] = 1'b0;
      end else if (pend_q[i] && (hw_clr[i] || sw_clr[i])) begin
        pend_d[i]     = 1'b0;
        ack_seen_d[i] = 1'b0;
        rel_seen_d[i] = 1'b0;
      end else if (pend_q[i]) begin
        ack_seen_d[i] = ack_v[i];
        rel_seen_d[i] = rel_v[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      mode_q     <= 1'b0;
      pend_q     <= '0;
      ack_seen_q <= '0;
      rel_seen_q <= '0;
    end else begin
      pend_q     <= pend_d;
      ack_seen_q <= ack_seen_d;
      rel_seen_q <= rel_seen_d;
      if (reg_we) begin
        en_q   <= reg_wdata[EN_LSB +: N_SRC];
        mode_q <= reg_wdata[MODE_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[EN_LSB +: N_SRC]     = en_q;
    reg_rdata[STAT_LSB +: N_SRC]   = pend_q;
    reg_rdata[MODE_BIT]            = mode_q;
  end

  assign dma_req_o = pend_q & en_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    p_set_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[g] && en_q[g]) |=> pend_q[g]);
    p_no_spont_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[g] && !(done_i[g] && en_q[g])) |=> !pend_q[g]);
    p_zero_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && reg_we && !reg_wdata[STAT_LSB+g] && !dma_ack_i[g] && !ack_seen_q[g])
      |=> pend_q[g]);
    p_latched_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && pend_q[g] && src_req_i[g] && !rel_seen_q[g]
       && !(reg_we && reg_wdata[STAT_LSB+g])) |=> pend_q[g]);
    p_pulse_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && pend_q[g] && dma_ack_i[g] && !(done_i[g] && en_q[g])) |=> !pend_q[g]);
    p_disable_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_wdata[EN_LSB+g]) |=> !dma_req_o[g]);
  end

endmodule

// File: tb/sim_adc_dma_req_gen.sv
module sim_adc_dma_req_gen;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] done_i = '0, src_req_i = '0, dma_ack_i = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] dma_req_o;

  adc_dma_req_gen u0 (.clk(clk), .rst_n(rst_n), .done_i(done_i), .src_req_i(src_req_i),
    .dma_ack_i(dma_ack_i), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req_o(dma_req_o));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [N-1:0] m_en = '0, m_pend = '0, m_ack = '0, m_rel = '0;
  logic m_mode = 1'b0;

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[7:0] = m_en; w[23:16] = m_pend; w[31] = m_mode;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " word"}, reg_rdata, exp_word());
    check({tag, " req"}, {24'd0, dma_req_o}, {24'd0, m_pend & m_en});
  endtask

  task automatic step(input logic [N-1:0] d, input logic [N-1:0] s, input logic [N-1:0] a,
                      input logic we, input logic [31:0] wd, input string tag);
    logic [N-1:0] np, na, nr;
    @(negedge clk);
    done_i = d; src_req_i = s; dma_ack_i = a; reg_we = we; reg_wdata = wd;
    np = m_pend; na = m_ack; nr = m_rel;
    for (int i = 0; i < N; i++) begin
      logic av, rv, hc;
      av = m_ack[i] | a[i];
      rv = m_rel[i] | ~s[i];
      hc = m_mode ? a[i] : (av & rv);
      if (d[i] && m_en[i]) begin np[i] = 1; na[i] = 0; nr[i] = 0; end
      else if (m_pend[i] && (hc || (we && wd[16+i]))) begin np[i] = 0; na[i] = 0; nr[i] = 0; end
      else if (m_pend[i]) begin na[i] = av; nr[i] = rv; end
    end
    @(posedge clk);
    m_pend = np; m_ack = na; m_rel = nr;
    if (we) begin m_en = wd[7:0]; m_mode = wd[31]; end
    #1;
    compare(tag);
  endtask

  task automatic idle(input logic [N-1:0] s, input string tag);
    step('0, s, '0, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] lvl;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 reset word", reg_rdata, 32'h0);
    check("R1 reset req", {24'd0, dma_req_o}, 32'h0);
    rst_n = 1'b1;

    step('0, '0, '0, 1'b1, 32'h0000_0001, "R5 write enables");
    check("R5 readback", reg_rdata, 32'h0000_0001);
    step(8'h02, '0, '0, 1'b0, '0, "R3 disabled event");
    check("R3 flag stays low", {24'd0, reg_rdata[23:16]}, 32'h0);
    step(8'h01, 8'h01, '0, 1'b0, '0, "R2 event sets");
    check("R2 req high", {31'd0, dma_req_o[0]}, 32'd1);
    check("R1 flag bit16", {31'd0, reg_rdata[16]}, 32'd1);
    step('0, 8'h01, 8'h01, 1'b0, '0, "R6 ack only");
    check("R6 held after ack", {31'd0, dma_req_o[0]}, 32'd1);
    idle(8'h01, "R6 still held");
    check("R6 held src high", {31'd0, dma_req_o[0]}, 32'd1);
    idle(8'h00, "R6 release after ack");
    check("R6 cleared by release", {31'd0, reg_rdata[16]}, 32'd0);
    step(8'h01, 8'h01, '0, 1'b0, '0, "R6 set again");
    idle(8'h00, "R6 release first");
    check("R6 held release only", {31'd0, dma_req_o[0]}, 32'd1);
    step('0, 8'h01, 8'h01, 1'b0, '0, "R6 ack after release");
    check("R6 cleared by ack", {31'd0, dma_req_o[0]}, 32'd0);

    step('0, 8'hFF, 8'h40, 1'b1, 32'h0000_00FF, "R10 stray ack");
    check("R10 no flag", {31'd0, reg_rdata[22]}, 32'd0);
    step(8'h40, 8'h00, '0, 1'b0, '0, "R10 event");
    check("R10 stray ack forgotten", {31'd0, dma_req_o[6]}, 32'd1);
    step('0, 8'h00, 8'h40, 1'b0, '0, "R10 clear");

    step('0, 8'h08, '0, 1'b1, 32'h8000_00FF, "R7 pulsed mode");
    step(8'h08, 8'h08, '0, 1'b0, '0, "R7 event");
    step('0, 8'h08, 8'h08, 1'b0, '0, "R7 ack");
    check("R7 cleared by ack alone", {31'd0, reg_rdata[19]}, 32'd0);

    step(8'h20, 8'h20, '0, 1'b0, '0, "R8 event");
    step(8'h20, 8'h20, 8'h20, 1'b0, '0, "R8 event with ack");
    check("R8 set wins over ack", {31'd0, dma_req_o[5]}, 32'd1);
    step(8'h20, 8'h20, '0, 1'b1, 32'h8020_00FF, "R8 event with sw clear");
    check("R8 set wins over clear", {31'd0, reg_rdata[21]}, 32'd1);

    step('0, 8'h20, '0, 1'b1, 32'h8000_007F, "R4 zero write");
    check("R4 zero keeps flag", {31'd0, reg_rdata[21]}, 32'd1);
    step('0, 8'h20, '0, 1'b1, 32'h8020_00FF, "R4 one write");
    check("R4 one clears flag", {31'd0, reg_rdata[21]}, 32'd0);

    step(8'h04, 8'h04, '0, 1'b0, '0, "R9 event");
    step('0, 8'h04, '0, 1'b1, 32'h8000_00FB, "R9 disable");
    check("R9 req drops", {31'd0, dma_req_o[2]}, 32'd0);
    check("R9 flag stays", {31'd0, reg_rdata[18]}, 32'd1);
    step('0, 8'h04, '0, 1'b1, 32'h8000_00FF, "R9 enable again");
    check("R9 req back", {31'd0, dma_req_o[2]}, 32'd1);

    lvl = '0;
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] d, a, flip;
      logic we;
      logic [31:0] wd;
      flip = 8'($urandom) & 8'($urandom) & 8'($urandom);
      lvl = lvl ^ flip;
      d = 8'($urandom) & 8'($urandom) & 8'($urandom);
      a = 8'($urandom) & 8'($urandom);
      we = ($urandom % 16) == 0;
      wd = {($urandom % 2) == 1, 7'd0, 8'($urandom) & 8'($urandom), 8'd0,
            (($urandom % 4) == 0) ? 8'($urandom) : 8'hFF};
      step(d, lvl, a, we, wd, "R2/R4/R6/R7/R8 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule